// File: doc/BRIEF.md
# Sector Overlap Suppression Logic

The block looks at the particle candidates reported by the 26 detector sectors of one octant. Sectors 0 to 11 are endcap sectors, 12 to 19 are barrel sectors and 20 to 25 are forward sectors. Neighbouring sectors can both report the same particle. For each fixed pair of sectors that can overlap, a programmable one-bit table indexed by the two candidates' position codes decides whether the two reports are one particle. When they are, the candidate with the lower momentum code gets a suppress flag, so a downstream counter counts the particle once.

The overlap tables are written one bit at a time through a simple write port. A table bit can be rewritten while candidates are flowing, which changes the overlap policy without any other action. Candidates are registered on entry and the flags are registered on exit. The flags therefore follow the candidates by two clock cycles, which fits easily inside a latency budget of three bunch crossings when the clock runs at four times the crossing rate.

Top module: `sector_overlap_suppress`

## Requirements
- R1: Reset drives every suppress flag to 0 and clears every overlap table bit. After reset, no input pattern produces a suppress flag until a table bit is written.
- R2: The suppress flags present after clock edge k+1 describe the candidates sampled at edge k. Before that, the flags still describe the earlier candidates.
- R3: There are 68 overlap pairs (first, second), numbered as follows:
  - Pairs 0-11 are (i, (i+1) mod 12).
  - Pairs 12-19 are (i, i+2) for i = 0..7.
  - Pair 20+4b+j is ((b+j) mod 12, 12+b) for b = 0..7, j = 0..3.
  - Pairs 52-59 are (12+i, 12+(i+1) mod 8).
  - Pairs 60-65 are (20+i, 20+(i+1) mod 6).
  - Pair 66 is (20,22) and pair 67 is (23,25).
  - No other pair of sectors can suppress one another.
- R4: A pair overlaps when bit {roi_first, roi_second} of its table is 1, with the first candidate's 3-bit position code in address bits 5:3. A write with cfg_we=1 at an edge stores cfg_data at table cfg_pair, bit cfg_addr. The new bit is used for candidates sampled from the next edge on. A write to a pair number of 68 or above changes nothing.
- R5: In an overlapping pair of two valid candidates, the one with the strictly lower 3-bit momentum code is suppressed and the other is not.
- R6: In an overlapping pair with equal momentum codes, the candidate with the higher sector number is suppressed.
- R7: A candidate whose valid bit is 0 is never suppressed and never causes another candidate to be suppressed.
- R8: A candidate is suppressed when it loses in at least one of its pairs. Being suppressed does not stop it from suppressing a weaker partner in another pair.
- R9: Rewriting a table bit to 0 at run time removes the suppression it caused, for later candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four times the crossing rate |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 26 | Valid bit per sector |
| cand_roi | input | 78 | 3-bit position code per sector, sector s at bits 3s+2:3s |
| cand_pt | input | 78 | 3-bit momentum code per sector, sector s at bits 3s+2:3s |
| cfg_we | input | 1 | Table write strobe |
| cfg_pair | input | 7 | Pair number of the table to write |
| cfg_addr | input | 6 | Bit address inside the table |
| cfg_data | input | 1 | Bit value to write |
| suppress | output | 26 | Suppress flag per sector |

## Verification
The hardest situation to reach is a candidate that sits in several pairs at once, where the pairs give different verdicts. One such case is a candidate that loses one pair but wins another. Another is a pair on a ring wrap, where the first sector has the higher number, with a momentum tie. The directed tasks set up these cases by writing only the relevant table bits and making only the involved sectors valid. A final task then loads dense random tables and drives random candidate words. This gives many multi-pair conflicts, which are checked against a model built from the pair list and the table mirror.

// File: rtl/olap_pkg.sv
package olap_pkg;

    localparam int N_EC    = 12;
    localparam int N_BA    = 8;
    localparam int N_FW    = 6;
    localparam int N_CAND  = N_EC + N_BA + N_FW;
    localparam int BA_BASE = N_EC;
    localparam int FW_BASE = N_EC + N_BA;

    localparam int NP_EE_RING = N_EC;
    localparam int NP_EE_SKIP = 8;
    localparam int BE_FAN     = 4;
    localparam int NP_BE      = N_BA * BE_FAN;
    localparam int NP_BB      = N_BA;
    localparam int NP_FF      = N_FW + 2;

    localparam int P_EE_SKIP = NP_EE_RING;
    localparam int P_BE      = P_EE_SKIP + NP_EE_SKIP;
    localparam int P_BB      = P_BE + NP_BE;
    localparam int P_FF      = P_BB + NP_BB;
    localparam int NP        = P_FF + NP_FF;
    localparam int PAIR_AW   = $clog2(NP);

    localparam int ROI_W = 3;
    localparam int PT_W  = 3;

    typedef struct packed {
        int unsigned first;
        int unsigned second;
    } pair_t;

    function automatic pair_t pair_of(input int p);
        pair_t r;
        int    q;
        if (p < P_EE_SKIP) begin
            r.first  = p;
            r.second = (p + 1) % N_EC;
        end else if (p < P_BE) begin
            q = p - P_EE_SKIP;
            r.first  = q;
            r.second = q + 2;
        end else if (p < P_BB) begin
            q = p - P_BE;
            r.first  = ((q / BE_FAN) + (q % BE_FAN)) % N_EC;
            r.second = BA_BASE + q / BE_FAN;
        end else if (p < P_FF) begin
            q = p - P_BB;
            r.first  = BA_BASE + q;
            r.second = BA_BASE + (q + 1) % N_BA;
        end else begin
            q = p - P_FF;
            if (q < N_FW) begin
                r.first  = FW_BASE + q;
                r.second = FW_BASE + (q + 1) % N_FW;
            end else if (q == N_FW) begin
                r.first  = FW_BASE;
                r.second = FW_BASE + 2;
            end else begin
                r.first  = FW_BASE + 3;
                r.second = FW_BASE + 5;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/olap_lut_bank.sv
module olap_lut_bank
    import olap_pkg::*;
#(
    parameter int RW = ROI_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [PAIR_AW-1:0]            cfg_pair,
    input  logic [2*RW-1:0]               cfg_addr,
    input  logic                          cfg_data,
    input  logic [N_CAND-1:0][RW-1:0]     roi,
    output logic [NP-1:0]                 hit
);

    localparam int LUT_D = 1 << (2 * RW);

    logic [LUT_D-1:0] tbl [NP];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NP; p++) tbl[p] <= '0;
        end else if (cfg_we && (int'(cfg_pair) < NP)) begin
            tbl[cfg_pair][cfg_addr] <= cfg_data;
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_look
        localparam pair_t PR = pair_of(p);
        assign hit[p] = tbl[p][{roi[PR.first], roi[PR.second]}];
    end

    // R4: a write lands in the addressed table bit
    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (int'(cfg_pair) < NP)) |=>
            tbl[$past(cfg_pair)][$past(cfg_addr)] == $past(cfg_data));

endmodule

// File: rtl/olap_pair_judge.sv
module olap_pair_judge
    import olap_pkg::*;
#(
    parameter int PW       = PT_W,
    parameter bit FIRST_HI = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          va,
    input  logic          vb,
    input  logic          hit,
    input  logic [PW-1:0] pta,
    input  logic [PW-1:0] ptb,
    output logic          kill_a,
    output logic          kill_b
);

    logic dup;
    logic tie;

    always_comb begin
        dup    = va && vb && hit;
        tie    = (pta == ptb);
        kill_a = dup && ((ptb > pta) || (tie && FIRST_HI));
        kill_b = dup && ((pta > ptb) || (tie && !FIRST_HI));
    end

    // R5: at most one loser per pair
    a_r5_one_loser: assert property (@(posedge clk) disable iff (rst)
        !(kill_a && kill_b));

    // R5: the loser never has the higher momentum
    a_r5_loser_weaker: assert property (@(posedge clk) disable iff (rst)
        kill_b |-> (pta >= ptb));

    // R7: no verdict without both candidates valid
    a_r7_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (kill_a || kill_b) |-> (va && vb));

endmodule

// File: rtl/sector_overlap_suppress.sv
module sector_overlap_suppress
    import olap_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CAND-1:0]         cand_valid,
    input  logic [N_CAND*ROI_W-1:0]   cand_roi,
    input  logic [N_CAND*PT_W-1:0]    cand_pt,
    input  logic                      cfg_we,
    input  logic [PAIR_AW-1:0]        cfg_pair,
    input  logic [2*ROI_W-1:0]        cfg_addr,
    input  logic                      cfg_data,
    output logic [N_CAND-1:0]         suppress
);

    logic [N_CAND-1:0]              valid_q;
    logic [N_CAND-1:0][ROI_W-1:0]   roi_q;
    logic [N_CAND-1:0][PT_W-1:0]    pt_q;
    logic [N_CAND-1:0]              supp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            roi_q   <= '0;
            pt_q    <= '0;
        end else begin
            valid_q <= cand_valid;
            roi_q   <= cand_roi;
            pt_q    <= cand_pt;
        end
    end

    logic [NP-1:0] hit;

    olap_lut_bank #(.RW(ROI_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_pair (cfg_pair),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .roi      (roi_q),
        .hit      (hit)
    );

    logic [NP-1:0]             kill_a;
    logic [NP-1:0]             kill_b;
    logic [NP-1:0][N_CAND-1:0] kmask;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        localparam pair_t PR = pair_of(p);
        olap_pair_judge #(
            .PW       (PT_W),
            .FIRST_HI (PR.first > PR.second)
        ) u_judge (
            .clk    (clk),
            .rst    (rst),
            .va     (valid_q[PR.first]),
            .vb     (valid_q[PR.second]),
            .hit    (hit[p]),
            .pta    (pt_q[PR.first]),
            .ptb    (pt_q[PR.second]),
            .kill_a (kill_a[p]),
            .kill_b (kill_b[p])
        );
        assign kmask[p] = ({{(N_CAND-1){1'b0}}, kill_a[p]} << PR.first)
                        | ({{(N_CAND-1){1'b0}}, kill_b[p]} << PR.second);
    end

    logic [N_CAND-1:0] supp_n;

    always_comb begin
        supp_n = '0;
        for (int p = 0; p < NP; p++) supp_n = supp_n | kmask[p];
    end

    always_ff @(posedge clk) begin
        if (rst) supp_q <= '0;
        else     supp_q <= supp_n;
    end

    assign suppress = supp_q;

    // R7: an invalid candidate never carries a flag
    a_r7_invalid_clear: assert property (@(posedge clk) disable iff (rst)
        (supp_q & ~$past(valid_q)) == '0);

    // R1: a lone candidate has nobody to lose to
    a_r1_lone_clear: assert property (@(posedge clk) disable iff (rst)
        ($countones(valid_q) <= 1) |=> (supp_q == '0));

endmodule

// File: tb/test_sector_overlap_suppress.sv
module test_sector_overlap_suppress;

    localparam int N  = 26;
    localparam int NP = 68;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    cand_valid = '0;
    logic [N*3-1:0]  cand_roi = '0;
    logic [N*3-1:0]  cand_pt = '0;
    logic            cfg_we = 1'b0;
    logic [6:0]      cfg_pair = '0;
    logic [5:0]      cfg_addr = '0;
    logic            cfg_data = 1'b0;
    logic [N-1:0]    suppress;

    sector_overlap_suppress i_sector_overlap_suppress (
        .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_roi(cand_roi),
        .cand_pt(cand_pt), .cfg_we(cfg_we), .cfg_pair(cfg_pair),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .suppress(suppress)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int pa [NP];
    int pb [NP];
    bit [63:0] mtbl [NP];

    logic [N-1:0]        v;
    logic [N-1:0][2:0]   r;
    logic [N-1:0][2:0]   t;

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic build_pairs();
        int k = 0;
        for (int i = 0; i < 12; i++) begin pa[k] = i; pb[k] = (i + 1) % 12; k++; end
        for (int i = 0; i < 8; i++)  begin pa[k] = i; pb[k] = i + 2; k++; end
        for (int b = 0; b < 8; b++)
            for (int j = 0; j < 4; j++) begin pa[k] = (b + j) % 12; pb[k] = 12 + b; k++; end
        for (int i = 0; i < 8; i++)  begin pa[k] = 12 + i; pb[k] = 12 + (i + 1) % 8; k++; end
        for (int i = 0; i < 6; i++)  begin pa[k] = 20 + i; pb[k] = 20 + (i + 1) % 6; k++; end
        pa[k] = 20; pb[k] = 22; k++;
        pa[k] = 23; pb[k] = 25;
    endtask

    function automatic logic [N-1:0] model(input logic [N-1:0] vv,
                                           input logic [N-1:0][2:0] rr,
                                           input logic [N-1:0][2:0] tt);
        logic [N-1:0] e = '0;
        for (int k = 0; k < NP; k++) begin
            int a = pa[k];
            int b = pb[k];
            if (vv[a] && vv[b] && mtbl[k][{rr[a], rr[b]}]) begin
                if (tt[a] > tt[b])      e[b] = 1'b1;
                else if (tt[b] > tt[a]) e[a] = 1'b1;
                else if (a > b)         e[a] = 1'b1;
                else                    e[b] = 1'b1;
            end
        end
        return e;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cand_valid = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NP; k++) mtbl[k] = '0;
    endtask

    task automatic wr(input int pair, input int addr, input bit d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pair = 7'(pair); cfg_addr = 6'(addr); cfg_data = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        if (pair < NP) mtbl[pair][addr] = d;
    endtask

    task automatic drive();
        @(negedge clk);
        cand_valid = v; cand_roi = r; cand_pt = t;
    endtask

    task automatic apply_and_wait();
        drive();
        @(posedge clk); @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        v = '0; r = '0; t = '0;
    endtask

    task automatic t_reset();
        v = '1;
        for (int s = 0; s < N; s++) begin r[s] = 3'd0; t[s] = 3'(s % 8); end
        @(negedge clk);
        check("R1 flags after reset", suppress, '0);
        apply_and_wait();
        check("R1 empty tables suppress nothing", suppress, '0);
    endtask

    task automatic t_latency();
        wr(0, {3'd2, 3'd5}, 1'b1);
        clear_inputs();
        apply_and_wait();
        v[0] = 1; v[1] = 1; r[0] = 3'd2; r[1] = 3'd5; t[0] = 3'd5; t[1] = 3'd2;
        drive();
        @(posedge clk); @(negedge clk);
        check("R2 one edge later still old value", suppress, '0);
        @(posedge clk); @(negedge clk);
        check("R2 two edges later lower pt flagged (R5)", suppress, 26'h2);
    endtask

    task automatic t_pt_order();
        clear_inputs();
        v[0] = 1; v[1] = 1; r[0] = 3'd2; r[1] = 3'd5; t[0] = 3'd1; t[1] = 3'd6;
        apply_and_wait();
        check("R5 first candidate weaker", suppress, 26'h1);
        r[0] = 3'd5; r[1] = 3'd2;
        apply_and_wait();
        check("R4 swapped position codes miss table bit", suppress, '0);
    endtask

    task automatic t_tie();
        clear_inputs();
        v[0] = 1; v[1] = 1; r[0] = 3'd2; r[1] = 3'd5; t[0] = 3'd4; t[1] = 3'd4;
        apply_and_wait();
        check("R6 tie drops higher sector 1", suppress, 26'h2);
        wr(11, {3'd7, 3'd0}, 1'b1);
        clear_inputs();
        v[11] = 1; v[0] = 1; r[11] = 3'd7; r[0] = 3'd0; t[11] = 3'd3; t[0] = 3'd3;
        apply_and_wait();
        check("R6 wrap pair tie drops sector 11", suppress, 26'h800);
    endtask

    task automatic t_invalid();
        clear_inputs();
        v[1] = 1; r[0] = 3'd2; r[1] = 3'd5; t[0] = 3'd7; t[1] = 3'd0;
        apply_and_wait();
        check("R7 invalid strong partner causes nothing", suppress, '0);
        v = '0; v[0] = 1; t[0] = 3'd0; t[1] = 3'd7;
        apply_and_wait();
        check("R7 invalid weak candidate not flagged", suppress, '0);
    endtask

    task automatic t_multi();
        wr(1, {3'd5, 3'd4}, 1'b1);
        clear_inputs();
        v[0] = 1; v[1] = 1; v[2] = 1;
        r[0] = 3'd2; r[1] = 3'd5; r[2] = 3'd4;
        t[0] = 3'd7; t[1] = 3'd4; t[2] = 3'd1;
        apply_and_wait();
        check("R8 loser still suppresses weaker partner", suppress, 26'h6);
    endtask

    task automatic t_regions();
        wr(20 + 4 * 3 + 2, {3'd1, 3'd6}, 1'b1);
        wr(59, {3'd3, 3'd3}, 1'b1);
        wr(66, {3'd0, 3'd7}, 1'b1);
        clear_inputs();
        v[5] = 1; v[15] = 1; r[5] = 3'd1; r[15] = 3'd6; t[5] = 3'd2; t[15] = 3'd5;
        v[19] = 1; v[12] = 1; r[19] = 3'd3; r[12] = 3'd3; t[19] = 3'd6; t[12] = 3'd6;
        v[20] = 1; v[22] = 1; r[20] = 3'd0; r[22] = 3'd7; t[20] = 3'd1; t[22] = 3'd2;
        apply_and_wait();
        check("R3 barrel-endcap, barrel ring tie, forward skip pair",
              suppress, (26'd1 << 5) | (26'd1 << 19) | (26'd1 << 20));
        wr(100, 0, 1'b1);
        clear_inputs();
        v[0] = 1; v[5] = 1; r[0] = 3'd0; r[5] = 3'd0; t[0] = 3'd7; t[5] = 3'd0;
        apply_and_wait();
        check("R3 unpaired sectors and out-of-range write (R4)", suppress, '0);
    endtask

    task automatic t_rewrite();
        wr(0, {3'd2, 3'd5}, 1'b0);
        clear_inputs();
        v[0] = 1; v[1] = 1; r[0] = 3'd2; r[1] = 3'd5; t[0] = 3'd5; t[1] = 3'd2;
        apply_and_wait();
        check("R9 cleared bit removes suppression", suppress, '0);
        wr(0, {3'd2, 3'd5}, 1'b1);
        apply_and_wait();
        check("R9 restored bit suppresses again", suppress, 26'h2);
    endtask

    task automatic t_random();
        do_reset();
        for (int k = 0; k < NP; k++)
            for (int a = 0; a < 64; a++)
                if ($urandom % 3 == 0) wr(k, a, 1'b1);
        for (int n = 0; n < 300; n++) begin
            for (int s = 0; s < N; s++) begin
                v[s] = ($urandom % 5) != 0;
                r[s] = 3'($urandom);
                t[s] = 3'($urandom);
            end
            apply_and_wait();
            check("R8 random pattern vs model (R5 R6 R7)", suppress, model(v, r, t));
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        build_pairs();
        clear_inputs();
        do_reset();
        t_reset();
        t_latency();
        t_pt_order();
        t_tie();
        t_invalid();
        t_multi();
        t_regions();
        t_rewrite();
        t_random();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule